// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block drives an 8-bit NAND flash device for a client that only names an operation. The client gives an operation code, a row address made of block and page bits, and a start column. The sequencer then produces the chip-enable, command-latch, address-latch, write-strobe and read-strobe waveforms. It moves the data bytes through valid/ready streams and returns a single done pulse that carries a pass/fail flag.

Three operations are supported: page read, page program and block erase. Every command and address byte is clocked into the device by a write-strobe pulse, and every byte read out needs one read-strobe pulse. After an operation starts, the sequencer watches the device's ready/busy line, and a timeout covers the case where the device hangs. A program or erase ends by reading the device's status byte. Strobe low and high widths, the read-sample point, the number of data bytes per page transfer and the busy limits are all parameters counted in clock cycles.

Top module: `nand_seq`

## Requirements
- R1: After reset, nf_ce_n, nf_we_n and nf_re_n are 1, nf_cle and nf_ale are 0, and busy and done are 0.
- R2: An operation is accepted only when op_valid is 1 while the sequencer is idle. The codes are 0 = read, 1 = program, 2 = erase. Code 3 is ignored: busy stays 0 and no write strobe is issued.
- R3: A read sends command byte 00h with nf_cle high. It then sends three address bytes with nf_ale high, in this order: the column, row[7:0], and row[14:8] zero-extended. After ready, it issues XFER_BYTES read strobes and delivers the bytes in order on rd_data/rd_valid.
- R4: A program sends command 80h, the same three address bytes, XFER_BYTES data bytes taken through the wr_valid/wr_ready handshake, and command 10h. It then waits for ready and sends status command 70h.
- R5: An erase sends command 60h and then two address bytes: row[7:0] with its five page bits cleared, and row[14:8] zero-extended. It then sends D0h, waits for ready and sends 70h.
- R6: For program and erase, fail at done equals bit 0 of the status byte read after 70h. A 0 in that bit means success and a 1 means an error.
- R7: Each write strobe is low for exactly WE_LO cycles, and each read strobe is low for exactly RE_LO cycles. The two strobes are never low together, and nf_cle, nf_ale and nf_dq_o stay constant while nf_we_n is low.
- R8: Read data is captured at the end of the SAMPLE_AT-th cycle after the read strobe falls. With a 10 ns clock and SAMPLE_AT = 4, this covers a 35 ns access time.
- R9: If ready/busy stays low for RB_TIMEOUT cycles, the operation ends with done and fail = 1, and nf_ce_n returns high.
- R10: busy is 1 from the cycle after acceptance through the cycle of a one-cycle done pulse. It is 0 after done. An op_valid raised while busy starts nothing.
- R11: While rd_valid is 1 and rd_ready is 0, no new read strobe is issued and rd_valid stays 1.
- R12: nf_dq_oe is 0 whenever nf_re_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 2 | 0 read, 1 program, 2 erase, 3 ignored |
| op_row | input | 15 | Block (bits 14:5) and page (bits 4:0) |
| op_col | input | 8 | Start column byte |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data present |
| wr_ready | output | 1 | Program data taken this cycle |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Client takes the read byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result flag, valid with done |
| nf_ce_n | output | 1 | Device chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Byte driven to the device |
| nf_dq_oe | output | 1 | Drive enable for nf_dq_o |
| nf_dq_i | input | 8 | Byte from the device |
| nf_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
A wrong step in the sequence shows up at the device pins within one strobe period. The symptoms are a misplaced or missing command byte, address bytes out of order, or a latch-enable level changing under a low write strobe. A model of the device logs every byte latched on a rising write strobe, so these errors appear as a mismatch in the logged sequence. A bad sample point or a lost stall on the read side shows as a wrong byte on rd_data at the next handshake. A broken busy wait shows either as a read of the status byte too early or as done never arriving before the timeout.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    localparam int NFC_BLOCKS = 1024;
    localparam int NFC_PAGES  = 32;
    localparam int ROW_W      = $clog2(NFC_BLOCKS * NFC_PAGES);
    localparam int PG_W       = $clog2(NFC_PAGES);

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_NONE  = 2'd3
    } op_t;

    localparam logic [7:0] CMD_READ     = 8'h00;
    localparam logic [7:0] CMD_PROG     = 8'h80;
    localparam logic [7:0] CMD_PROG_GO  = 8'h10;
    localparam logic [7:0] CMD_ERASE    = 8'h60;
    localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
    localparam logic [7:0] CMD_STATUS   = 8'h70;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_CMD1, SQ_ADDR, SQ_WDATA, SQ_CMD2, SQ_WAIT,
        SQ_RDATA, SQ_RHOLD, SQ_STCMD, SQ_STRD, SQ_FINISH
    } seq_t;

    typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} ph_t;

    typedef struct packed {
        op_t              op;
        logic [7:0]       col;
        logic [ROW_W-1:0] row;
    } req_t;

    function automatic logic [7:0] first_cmd(op_t op);
        case (op)
            OP_PROG:  return CMD_PROG;
            OP_ERASE: return CMD_ERASE;
            default:  return CMD_READ;
        endcase
    endfunction

    function automatic logic [7:0] second_cmd(op_t op);
        return (op == OP_ERASE) ? CMD_ERASE_GO : CMD_PROG_GO;
    endfunction

    function automatic logic [1:0] last_addr(op_t op);
        return (op == OP_ERASE) ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [7:0] addr_byte(req_t r, logic [1:0] idx);
        logic [7:0] lo;
        logic [7:0] hi;
        lo = r.row[7:0];
        hi = 8'(r.row >> 8);
        if (r.op == OP_ERASE)
            return (idx == 2'd0) ? (lo & 8'(8'hFF << PG_W)) : hi;
        case (idx)
            2'd0:    return r.col;
            2'd1:    return lo;
            default: return hi;
        endcase
    endfunction

endpackage

// File: rtl/nfc_strobe.sv
module nfc_strobe
    import nfc_pkg::*;
#(
    parameter int WE_LO     = 2,
    parameter int WE_HI     = 2,
    parameter int RE_LO     = 4,
    parameter int RE_HI     = 2,
    parameter int SAMPLE_AT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic use_re,
    output logic we_n,
    output logic re_n,
    output logic smp,
    output logic fin
);

    localparam int MAXA = (WE_LO > WE_HI) ? WE_LO : WE_HI;
    localparam int MAXB = (RE_LO > RE_HI) ? RE_LO : RE_HI;
    localparam int MAXL = (MAXA > MAXB) ? MAXA : MAXB;
    localparam int CW   = $clog2(MAXL + 1);

    ph_t           ph;
    logic [CW-1:0] cnt;
    logic          kind;
    logic [CW-1:0] lo_len;
    logic [CW-1:0] hi_len;

    assign lo_len = kind ? CW'(RE_LO) : CW'(WE_LO);
    assign hi_len = kind ? CW'(RE_HI) : CW'(WE_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            kind <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: if (start) begin
                    ph   <= PH_LO;
                    cnt  <= CW'(1);
                    kind <= use_re;
                end
                PH_LO: if (cnt == lo_len) begin
                    ph  <= PH_HI;
                    cnt <= CW'(1);
                end else begin
                    cnt <= cnt + CW'(1);
                end
                PH_HI: if (cnt == hi_len) begin
                    ph <= PH_IDLE;
                end else begin
                    cnt <= cnt + CW'(1);
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign we_n = !(ph == PH_LO && !kind);
    assign re_n = !(ph == PH_LO && kind);
    assign smp  = (ph == PH_LO) && kind && (cnt == CW'(SAMPLE_AT));
    assign fin  = (ph == PH_HI) && (cnt == hi_len);

endmodule

// File: rtl/nfc_rbwait.sv
module nfc_rbwait #(
    parameter int GUARD   = 8,
    parameter int TIMEOUT = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rb,
    output logic ok,
    output logic tmo
);

    localparam int CW = $clog2(TIMEOUT + 1);

    logic          s1, s2;
    logic          act;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= 1'b1;
            s2  <= 1'b1;
            act <= 1'b0;
            cnt <= '0;
        end else begin
            s1 <= rb;
            s2 <= s1;
            if (start) begin
                act <= 1'b1;
                cnt <= '0;
            end else if (act) begin
                if (ok || tmo)
                    act <= 1'b0;
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign ok  = act && (cnt >= CW'(GUARD)) && s2;
    assign tmo = act && !ok && (cnt == CW'(TIMEOUT - 1));

endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nfc_pkg::*;
#(
    parameter int XFER_BYTES = 528,
    parameter int WE_LO      = 2,
    parameter int WE_HI      = 2,
    parameter int RE_LO      = 4,
    parameter int RE_HI      = 2,
    parameter int SAMPLE_AT  = 4,
    parameter int RB_GUARD   = 8,
    parameter int RB_TIMEOUT = 100000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [1:0]          op_code,
    input  logic [ROW_W-1:0]    op_row,
    input  logic [7:0]          op_col,
    input  logic [7:0]          wr_data,
    input  logic                wr_valid,
    output logic                wr_ready,
    output logic [7:0]          rd_data,
    output logic                rd_valid,
    input  logic                rd_ready,
    output logic                busy,
    output logic                done,
    output logic                fail,
    output logic                nf_ce_n,
    output logic                nf_cle,
    output logic                nf_ale,
    output logic                nf_we_n,
    output logic                nf_re_n,
    output logic [7:0]          nf_dq_o,
    output logic                nf_dq_oe,
    input  logic [7:0]          nf_dq_i,
    input  logic                nf_rb
);

    localparam int BW = (XFER_BYTES > 1) ? $clog2(XFER_BYTES) : 1;
    localparam logic [BW-1:0] LAST_BYTE = BW'(XFER_BYTES - 1);

    seq_t          state;
    req_t          req;
    logic          act;
    logic [1:0]    aidx;
    logic [BW-1:0] bcnt;
    logic          st_go, use_re, w_go;
    logic [7:0]    nbyte;
    logic          smp, fin, rb_ok, rb_tmo;

    nfc_strobe #(
        .WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO), .RE_HI(RE_HI),
        .SAMPLE_AT(SAMPLE_AT)
    ) i_strobe (
        .clk(clk), .rst(rst), .start(st_go), .use_re(use_re),
        .we_n(nf_we_n), .re_n(nf_re_n), .smp(smp), .fin(fin)
    );

    nfc_rbwait #(.GUARD(RB_GUARD), .TIMEOUT(RB_TIMEOUT)) i_rbwait (
        .clk(clk), .rst(rst), .start(w_go), .rb(nf_rb),
        .ok(rb_ok), .tmo(rb_tmo)
    );

    always_comb begin
        st_go  = 1'b0;
        use_re = 1'b0;
        w_go   = 1'b0;
        nbyte  = 8'h00;
        case (state)
            SQ_CMD1:  begin st_go = !act; nbyte = first_cmd(req.op); end
            SQ_ADDR:  begin st_go = !act; nbyte = addr_byte(req, aidx); end
            SQ_WDATA: begin st_go = !act && wr_valid; nbyte = wr_data; end
            SQ_CMD2:  begin st_go = !act; nbyte = second_cmd(req.op); end
            SQ_STCMD: begin st_go = !act; nbyte = CMD_STATUS; end
            SQ_RDATA, SQ_STRD: begin st_go = !act; use_re = 1'b1; end
            SQ_WAIT:  w_go = !act;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            req     <= '0;
            act     <= 1'b0;
            aidx    <= '0;
            bcnt    <= '0;
            fail    <= 1'b0;
            nf_dq_o <= '0;
            rd_data <= '0;
        end else begin
            if (st_go) begin
                act <= 1'b1;
                if (!use_re)
                    nf_dq_o <= nbyte;
            end
            if (w_go)
                act <= 1'b1;
            case (state)
                SQ_IDLE: if (op_valid && op_t'(op_code) != OP_NONE) begin
                    req   <= '{op: op_t'(op_code), col: op_col, row: op_row};
                    fail  <= 1'b0;
                    aidx  <= '0;
                    bcnt  <= '0;
                    state <= SQ_CMD1;
                end
                SQ_CMD1: if (fin) begin
                    act   <= 1'b0;
                    state <= SQ_ADDR;
                end
                SQ_ADDR: if (fin) begin
                    act <= 1'b0;
                    if (aidx == last_addr(req.op)) begin
                        aidx  <= '0;
                        state <= (req.op == OP_READ) ? SQ_WAIT :
                                 (req.op == OP_PROG) ? SQ_WDATA : SQ_CMD2;
                    end else begin
                        aidx <= aidx + 2'd1;
                    end
                end
                SQ_WDATA: if (fin) begin
                    act <= 1'b0;
                    if (bcnt == LAST_BYTE) begin
                        bcnt  <= '0;
                        state <= SQ_CMD2;
                    end else begin
                        bcnt <= bcnt + BW'(1);
                    end
                end
                SQ_CMD2: if (fin) begin
                    act   <= 1'b0;
                    state <= SQ_WAIT;
                end
                SQ_WAIT: if (act && rb_ok) begin
                    act   <= 1'b0;
                    state <= (req.op == OP_READ) ? SQ_RDATA : SQ_STCMD;
                end else if (act && rb_tmo) begin
                    act   <= 1'b0;
                    fail  <= 1'b1;
                    state <= SQ_FINISH;
                end
                SQ_RDATA: begin
                    if (smp)
                        rd_data <= nf_dq_i;
                    if (fin) begin
                        act   <= 1'b0;
                        state <= SQ_RHOLD;
                    end
                end
                SQ_RHOLD: if (rd_ready) begin
                    if (bcnt == LAST_BYTE) begin
                        state <= SQ_FINISH;
                    end else begin
                        bcnt  <= bcnt + BW'(1);
                        state <= SQ_RDATA;
                    end
                end
                SQ_STCMD: if (fin) begin
                    act   <= 1'b0;
                    state <= SQ_STRD;
                end
                SQ_STRD: begin
                    if (smp)
                        fail <= nf_dq_i[0];
                    if (fin) begin
                        act   <= 1'b0;
                        state <= SQ_FINISH;
                    end
                end
                SQ_FINISH: state <= SQ_IDLE;
                default:   state <= SQ_IDLE;
            endcase
        end
    end

    assign wr_ready = (state == SQ_WDATA) && !act;
    assign rd_valid = (state == SQ_RHOLD);
    assign busy     = (state != SQ_IDLE);
    assign done     = (state == SQ_FINISH);
    assign nf_ce_n  = (state == SQ_IDLE) || (state == SQ_FINISH);
    assign nf_cle   = (state == SQ_CMD1) || (state == SQ_CMD2) || (state == SQ_STCMD);
    assign nf_ale   = (state == SQ_ADDR);
    assign nf_dq_oe = nf_cle || nf_ale || (state == SQ_WDATA);

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic       nf_ce_n,
    input logic       nf_cle,
    input logic       nf_ale,
    input logic       nf_we_n,
    input logic       nf_re_n,
    input logic [7:0] nf_dq_o,
    input logic       nf_dq_oe
);

    // R7: latch controls and data hold while the write strobe is low
    p_ctl_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (!nf_we_n && $past(!nf_we_n)) |-> ($stable(nf_cle) && $stable(nf_ale) && $stable(nf_dq_o)));

    // R7: the two strobes never overlap
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(!nf_we_n && !nf_re_n));

    // R12: no drive while the device drives the bus
    p_no_contend_r12: assert property (@(posedge clk) disable iff (rst)
        !nf_re_n |-> !nf_dq_oe);

    // R10: done is a single-cycle pulse inside busy
    p_done_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1: chip enable released whenever idle
    p_ce_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> nf_ce_n);

    // R11: a stalled read byte blocks the next read strobe
    p_stall_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (nf_re_n && rd_valid));

endmodule

bind nand_seq nand_seq_chk i_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe)
);

// File: tb/test_nand_seq.sv
module test_nand_seq;

    localparam int XFER    = 6;
    localparam int WLO     = 2;
    localparam int WHI     = 2;
    localparam int RLO     = 4;
    localparam int RHI     = 2;
    localparam int SMP     = 4;
    localparam int GUARD   = 8;
    localparam int TMO     = 300;
    localparam int BUSY_CY = 50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic [14:0] op_row = '0;
    logic [7:0]  op_col = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic        busy, done, fail;
    logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0]  nf_dq_o;
    logic [7:0]  dev_dq = 8'hEE;
    logic        nf_rb = 1'b1;

    always #5 clk = ~clk;

    nand_seq #(
        .XFER_BYTES(XFER), .WE_LO(WLO), .WE_HI(WHI), .RE_LO(RLO), .RE_HI(RHI),
        .SAMPLE_AT(SMP), .RB_GUARD(GUARD), .RB_TIMEOUT(TMO)
    ) i_nand_seq (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_row(op_row), .op_col(op_col), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .busy(busy), .done(done),
        .fail(fail), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o),
        .nf_dq_oe(nf_dq_oe), .nf_dq_i(dev_dq), .nf_rb(nf_rb)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic       hang = 1'b0;
    logic       stat_err = 1'b0;
    logic [8:0] log_b [0:63];
    int         log_n = 0;
    logic       we_d = 1'b1;
    logic [7:0] last_cmd = 8'hFF;
    int         acnt = 0;
    logic [7:0] a0 = 0, a1 = 0;
    int         bcnt = 0;
    logic       status_mode = 1'b0;
    int         epoch = 0;

    always @(posedge clk) begin
        logic bstart;
        bstart = 1'b0;
        we_d <= nf_we_n;
        if (nf_we_n && !we_d) begin
            if (log_n < 64) log_b[log_n] <= {nf_cle, nf_ale, nf_dq_o};
            log_n <= log_n + 1;
            if (nf_cle) begin
                last_cmd    <= nf_dq_o;
                acnt        <= 0;
                status_mode <= (nf_dq_o == 8'h70);
                if (nf_dq_o == 8'h10 || nf_dq_o == 8'hD0) bstart = 1'b1;
            end else if (nf_ale) begin
                if (acnt == 0) a0 <= nf_dq_o;
                if (acnt == 1) a1 <= nf_dq_o;
                acnt <= acnt + 1;
                if (last_cmd == 8'h00 && acnt == 2) begin
                    bstart = 1'b1;
                    epoch <= epoch + 1;
                end
            end
        end
        if (bstart) bcnt <= BUSY_CY;
        else if (bcnt != 0) bcnt <= bcnt - 1;
        nf_rb <= !(bstart || bcnt > 1 || hang);
    end

    int seen_epoch = 0;
    int rptr = 0;
    always @(negedge nf_re_n) begin
        dev_dq <= 8'hEE;
        #35;
        if (status_mode) begin
            dev_dq <= 8'hC0 | {7'd0, stat_err};
        end else begin
            if (epoch != seen_epoch) begin
                seen_epoch = epoch;
                rptr = 0;
            end
            dev_dq <= a0 ^ a1 ^ 8'(rptr * 37);
            rptr = rptr + 1;
        end
    end

    // ---------------- pin monitors ----------------
    int we_run = 0, we_min = 99, we_max = 0;
    int re_run = 0, re_min = 99, re_max = 0;
    int re_falls = 0;
    int contend = 0;
    logic re_prev = 1'b1;
    always @(negedge clk) begin
        if (!nf_we_n) we_run++;
        else if (we_run != 0) begin
            if (we_run < we_min) we_min = we_run;
            if (we_run > we_max) we_max = we_run;
            we_run = 0;
        end
        if (!nf_re_n) re_run++;
        else if (re_run != 0) begin
            if (re_run < re_min) re_min = re_run;
            if (re_run > re_max) re_max = re_run;
            re_run = 0;
        end
        if (!nf_re_n && re_prev) re_falls++;
        re_prev = nf_re_n;
        if (!nf_re_n && nf_dq_oe) contend++;
    end

    // ---------------- helpers ----------------
    task automatic start_op(input logic [1:0] code, input logic [14:0] row, input logic [7:0] col);
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = code;
        op_row   = row;
        op_col   = col;
        @(negedge clk);
        op_valid = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    endtask

    task automatic wait_done(output logic f, output int cyc);
        cyc = 0;
        while (!done && cyc < 5000) begin
            chk(busy == 1'b1, "R10 busy held until done", busy, 1);
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R10 done arrives", done, 1);
        f = fail;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R10 done one cycle then idle", {done, busy}, 0);
    endtask

    task automatic chk_log(input int base, input int idx, input logic [8:0] exp, input string tag);
        chk(log_b[base + idx] == exp, tag, log_b[base + idx], exp);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(nf_ce_n && nf_we_n && nf_re_n, "R1 strobes and CE high", {nf_ce_n, nf_we_n, nf_re_n}, 3'b111);
        chk(!nf_cle && !nf_ale, "R1 latch enables low", {nf_cle, nf_ale}, 0);
        chk(!busy && !done, "R1 busy and done low", {busy, done}, 0);
    endtask

    task automatic t_reject();
        int base;
        base = log_n;
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = 2'd3;
        @(negedge clk);
        op_valid = 1'b0;
        repeat (20) begin
            @(negedge clk);
            chk(!busy, "R2 code 3 ignored busy", busy, 0);
        end
        chk(log_n == base, "R2 code 3 no strobe", log_n - base, 0);
    endtask

    task automatic t_read(input logic [14:0] row, input logic [7:0] col, input logic stall);
        int base, cyc;
        logic f;
        base = log_n;
        start_op(2'd0, row, col);
        for (int i = 0; i < XFER; i++) begin
            int guard;
            guard = 0;
            while (!rd_valid && guard < 2000) begin
                @(negedge clk);
                guard++;
            end
            chk(rd_data == (col ^ row[7:0] ^ 8'(i * 37)), "R8 read byte", rd_data, col ^ row[7:0] ^ 8'(i * 37));
            if (stall && i == 2) begin
                int falls0;
                falls0 = re_falls;
                repeat (30) @(negedge clk);
                chk(re_falls == falls0, "R11 no strobe while stalled", re_falls - falls0, 0);
                chk(rd_valid == 1'b1, "R11 byte held while stalled", rd_valid, 1);
            end
            rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0;
        end
        wait_done(f, cyc);
        chk(f == 1'b0, "R3 read no fail", f, 0);
        chk(log_n - base == 4, "R3 read byte count", log_n - base, 4);
        chk_log(base, 0, {2'b10, 8'h00}, "R3 read command");
        chk_log(base, 1, {2'b01, col}, "R3 column byte");
        chk_log(base, 2, {2'b01, row[7:0]}, "R3 row low byte");
        chk_log(base, 3, {2'b01, 1'b0, row[14:8]}, "R3 row high byte");
    endtask

    task automatic t_program(input logic [14:0] row, input logic [7:0] col, input logic err);
        int base, cyc;
        logic f;
        logic [7:0] d [0:5];
        d[0] = 8'hA5; d[1] = 8'h5A; d[2] = 8'h01; d[3] = 8'hFE; d[4] = 8'h33; d[5] = 8'hC7;
        stat_err = err;
        base = log_n;
        start_op(2'd1, row, col);
        // R10: request raised while busy must start nothing
        op_valid = 1'b1;
        op_code  = 2'd2;
        @(negedge clk);
        op_valid = 1'b0;
        for (int i = 0; i < XFER; i++) begin
            wr_data  = d[i];
            wr_valid = 1'b1;
            while (!wr_ready) @(negedge clk);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        wait_done(f, cyc);
        chk(f == err, "R6 program status bit", f, err);
        chk(log_n - base == 4 + XFER + 2, "R4 program byte count", log_n - base, 4 + XFER + 2);
        chk_log(base, 0, {2'b10, 8'h80}, "R4 program command");
        chk_log(base, 1, {2'b01, col}, "R4 column byte");
        chk_log(base, 2, {2'b01, row[7:0]}, "R4 row low byte");
        chk_log(base, 3, {2'b01, 1'b0, row[14:8]}, "R4 row high byte");
        for (int i = 0; i < XFER; i++)
            chk_log(base, 4 + i, {2'b00, d[i]}, "R4 data byte");
        chk_log(base, 4 + XFER, {2'b10, 8'h10}, "R4 confirm command");
        chk_log(base, 5 + XFER, {2'b10, 8'h70}, "R4 status command");
        repeat (5) @(negedge clk);
        chk(!busy && log_n - base == 4 + XFER + 2, "R10 no second op", log_n - base, 4 + XFER + 2);
    endtask

    task automatic t_erase(input logic [14:0] row, input logic err);
        int base, cyc;
        logic f;
        stat_err = err;
        base = log_n;
        start_op(2'd2, row, 8'h77);
        wait_done(f, cyc);
        chk(f == err, "R6 erase status bit", f, err);
        chk(log_n - base == 5, "R5 erase byte count", log_n - base, 5);
        chk_log(base, 0, {2'b10, 8'h60}, "R5 erase command");
        chk_log(base, 1, {2'b01, row[7:0] & 8'hE0}, "R5 block low byte");
        chk_log(base, 2, {2'b01, 1'b0, row[14:8]}, "R5 block high byte");
        chk_log(base, 3, {2'b10, 8'hD0}, "R5 confirm command");
        chk_log(base, 4, {2'b10, 8'h70}, "R5 status command");
    endtask

    task automatic t_timeout();
        int cyc;
        logic f;
        hang = 1'b1;
        stat_err = 1'b0;
        start_op(2'd2, 15'h0040, 8'h00);
        wait_done(f, cyc);
        chk(f == 1'b1, "R9 timeout fail", f, 1);
        chk(cyc >= TMO, "R9 timeout not early", cyc, TMO);
        chk(nf_ce_n == 1'b1, "R9 CE released", nf_ce_n, 1);
        hang = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_pins();
        chk(we_min == WLO && we_max == WLO, "R7 write strobe width", we_max, WLO);
        chk(re_min == RLO && re_max == RLO, "R7 read strobe width", re_max, RLO);
        chk(contend == 0, "R12 no drive during read strobe", contend, 0);
    endtask

    // ---------------- main ----------------
    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_reject();
        t_read(15'h5A3C, 8'h11, 1'b0);
        t_read(15'h7FFF, 8'h00, 1'b1);
        t_program(15'h1234, 8'h00, 1'b0);
        t_program(15'h0001, 8'h20, 1'b1);
        t_erase(15'h0ABF, 1'b0);
        t_erase(15'h7FE5, 1'b1);
        t_timeout();
        t_read(15'h0100, 8'hF0, 1'b0);
        t_pins();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule